// File: doc/BRIEF.md
# Serial Memory Streaming Read Front End

This block is the serial-peripheral slave front end that serves read requests for a 128 KiB memory. It oversamples the active-low select, the serial clock and the serial data input with the system clock. When select falls it collects an 8-bit command and a 24-bit byte address, both most significant bit first. The command is sampled on rising serial-clock edges, as in SPI mode 0. If the command is the read code, the block fetches bytes from a synchronous memory read port and shifts them out, most significant bit first. The output changes on falling serial-clock edges, and the stream continues until select rises.

The byte after the current one is fetched and buffered while the current byte is still shifting, so consecutive bytes follow with no idle serial-clock cycles. The address counts up after every fetch and wraps from the top location to zero, so one transaction can read the whole array. Any other command makes the block ignore the rest of the transaction. The output enable stays low except while a read data phase is active. Each serial-clock half period must last at least six system-clock cycles.

Control is one state machine. The states are:
- IDLE: waiting for select to fall.
- CMD: shifting in the command.
- ADDR: shifting in the address.
- FETCH_REQ: strobing the first read.
- FETCH_WAIT: taking the first byte.
- STREAM: shifting out data.
- DROP: ignoring the rest of an unsupported transaction.

The transitions are:
- start: IDLE to CMD on a select fall.
- accept: CMD to ADDR on the read code.
- reject: CMD to DROP on any other code.
- addressed: ADDR to FETCH_REQ after the 24th address bit.
- issue: FETCH_REQ to FETCH_WAIT.
- first_byte: FETCH_WAIT to STREAM when the read data returns.
- abort: any state to IDLE whenever select is high.

Top module: `spi_rdseq`

## Requirements
- R1: A transaction begins only on a falling edge of the select input. The 8 command bits are then sampled from the data input on rising serial-clock edges, most significant bit first.
- R2: Command value 0x03 selects a read. Any other command value keeps spi_miso_oe at 0 for the rest of that transaction.
- R3: After a read command, 24 address bits follow, most significant bit first. Only the low 17 bits select the starting byte, and the upper 7 bits have no effect on the data returned.
- R4: Once the last address bit is taken, the data input has no effect on the bytes returned for the rest of the transaction.
- R5: Each byte is shifted out with bit 7 first and bit 0 last, and spi_miso changes after falling serial-clock edges. Bit 7 of the first byte is valid before the first rising edge that follows the address.
- R6: After each byte the address advances by one, and the next byte's bit 7 is valid at the very next rising edge, with no gap clocks.
- R7: After the byte at address 0x1FFFF the stream continues with the byte at address 0x00000.
- R8: Raising the select input ends the transaction at any bit, including inside a byte. spi_miso_oe falls within a few system clocks, and a following transaction starts afresh.
- R9: spi_miso_oe is 0 after reset, while select is high, and during the command and address phases. Each mem_rd strobe lasts exactly one system-clock cycle, and mem_rdata is taken on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Active-low select |
| spi_sck | input | 1 | Serial clock (mode 0) |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for the serial data pad |
| mem_rd | output | 1 | One-cycle read strobe to the memory |
| mem_addr | output | 17 | Byte address of the read |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_rd |

## Verification
The hardest situation to reach is the wrap from the top location to zero in the middle of a stream. It needs a transaction that starts two bytes below the top and keeps select low across four bytes. The bench sets the start address directly and pads the unused upper address bits with ones, so the same transfer also checks that those bits are ignored. A sweep of start addresses and burst lengths, run while the data input toggles, covers the streaming path. A read aborted inside a byte checks that the next transaction recovers cleanly.

// File: rtl/spi_rdseq_pkg.sv
package spi_rdseq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_FETCH_REQ,
        ST_FETCH_WAIT,
        ST_STREAM,
        ST_DROP
    } seq_state_t;
endpackage

// File: rtl/spi_rdseq_sync.sv
module spi_rdseq_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[s] <= RST_VAL;
                    else        stg[s] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[s] <= RST_VAL;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/spi_rdseq_addr.sv
module spi_rdseq_addr #(
    parameter int ADDR_W = 17,
    parameter int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    logic [ADDR_W-1:0] addr_inc;
    assign addr_inc = (addr == LAST) ? '0 : addr + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     addr <= '0;
        else if (load)  addr <= load_val;
        else if (step)  addr <= addr_inc;
    end

    assert_wrap_to_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && addr == LAST) |=> addr == '0);
    assert_step_by_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && addr != LAST) |=> addr == $past(addr) + 1'b1);
endmodule

// File: rtl/spi_rdseq_txsr.sv
module spi_rdseq_txsr #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load_first,
    input  logic              fill_buf,
    input  logic [DATA_W-1:0] rdata,
    input  logic              rise_en,
    input  logic              fall_en,
    output logic              bit_out,
    output logic              pf_req
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

    logic [DATA_W-1:0] sh;
    logic [DATA_W-1:0] nbuf;
    logic              nbuf_valid;
    logic [CNT_W-1:0]  cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= '0; nbuf <= '0; nbuf_valid <= 1'b0; cnt <= '0; pf_req <= 1'b0;
        end else if (clear) begin
            sh <= '0; nbuf_valid <= 1'b0; cnt <= '0; pf_req <= 1'b0;
        end else begin
            pf_req <= 1'b0;
            if (load_first) begin
                sh     <= rdata;
                cnt    <= '0;
                pf_req <= 1'b1;
            end
            if (fill_buf) begin
                nbuf       <= rdata;
                nbuf_valid <= 1'b1;
            end
            if (rise_en && cnt != FULL) cnt <= cnt + 1'b1;
            if (fall_en) begin
                if (cnt == FULL) begin
                    sh         <= nbuf;
                    nbuf_valid <= 1'b0;
                    cnt        <= '0;
                    pf_req     <= 1'b1;
                end else if (cnt != '0) begin
                    sh <= {sh[DATA_W-2:0], 1'b0};
                end
            end
        end
    end

    assign bit_out = sh[DATA_W-1];

    assert_next_byte_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && fall_en && cnt == FULL) |-> nbuf_valid);
    assert_msb_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !load_first && fall_en && cnt != FULL && cnt != '0) |=> bit_out == $past(sh[DATA_W-2]));
endmodule

// File: rtl/spi_rdseq.sv
module spi_rdseq
    import spi_rdseq_pkg::*;
#(
    parameter int          ADDR_W     = 17,
    parameter int          DATA_W     = 8,
    parameter int          CMD_W      = 8,
    parameter int          ADDR_BYTES = 3,
    parameter int          SYNC_STG   = 2,
    parameter logic [7:0]  READ_OP    = 8'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int ADDR_BITS = ADDR_BYTES * 8;
    localparam int CNT_W     = $clog2(ADDR_BITS);
    localparam int SR_W      = ADDR_W - 1;
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_BITS - 1);

    // synchronized pins: bit2 = select, bit1 = clock, bit0 = data
    logic [2:0] pins_s;
    spi_rdseq_sync #(.WIDTH(3), .STAGES(SYNC_STG), .RST_VAL(3'b100)) sync_i (
        .clk(clk), .rst_n(rst_n),
        .din({spi_cs_n, spi_sck, spi_mosi}),
        .dout(pins_s)
    );

    logic cs_s, sck_s, mosi_s, cs_prev, sck_prev;
    logic cs_fall, sck_rise, sck_fall;
    assign cs_s   = pins_s[2];
    assign sck_s  = pins_s[1];
    assign mosi_s = pins_s[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_prev  <= 1'b1;
            sck_prev <= 1'b0;
        end else begin
            cs_prev  <= cs_s;
            sck_prev <= sck_s;
        end
    end

    assign cs_fall  = cs_prev & ~cs_s;
    assign sck_rise = ~cs_s & sck_s & ~sck_prev;
    assign sck_fall = ~cs_s & ~sck_s & sck_prev;

    seq_state_t state, state_nx;
    logic [CNT_W-1:0] bit_cnt;
    logic [SR_W-1:0]  in_sr;
    logic [CMD_W-1:0] opcode_q;
    logic             rd_q;
    logic [CMD_W-1:0] opcode_w;
    logic [ADDR_W-1:0] addr_w;

    assign opcode_w = {in_sr[CMD_W-2:0], mosi_s};
    assign addr_w   = {in_sr, mosi_s};

    // next-state logic
    always_comb begin
        state_nx = state;
        if (cs_s) begin
            state_nx = ST_IDLE;                               // abort
        end else begin
            unique case (state)
                ST_IDLE:       if (cs_fall) state_nx = ST_CMD; // start
                ST_CMD:        if (sck_rise && bit_cnt == CMD_LAST)
                                   state_nx = (opcode_w == READ_OP) ? ST_ADDR : ST_DROP;
                ST_ADDR:       if (sck_rise && bit_cnt == ADDR_LAST) state_nx = ST_FETCH_REQ;
                ST_FETCH_REQ:  state_nx = ST_FETCH_WAIT;       // issue
                ST_FETCH_WAIT: if (rd_q) state_nx = ST_STREAM; // first_byte
                ST_STREAM:     state_nx = ST_STREAM;
                ST_DROP:       state_nx = ST_DROP;
                default:       state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // input shifting and bit counting for command and address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            in_sr    <= '0;
            opcode_q <= '0;
            rd_q     <= 1'b0;
        end else begin
            rd_q <= mem_rd;
            if (state == ST_IDLE) begin
                bit_cnt <= '0;
            end else if ((state == ST_CMD || state == ST_ADDR) && sck_rise) begin
                in_sr <= {in_sr[SR_W-2:0], mosi_s};
                if (state == ST_CMD && bit_cnt == CMD_LAST) begin
                    opcode_q <= opcode_w;
                    bit_cnt  <= '0;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    // outputs and datapath controls
    logic addr_load, tx_clear, load_first, fill_buf, rise_en, fall_en, pf_req, tx_bit;
    always_comb begin
        addr_load   = 1'b0;
        tx_clear    = 1'b1;
        load_first  = 1'b0;
        fill_buf    = 1'b0;
        rise_en     = 1'b0;
        fall_en     = 1'b0;
        mem_rd      = 1'b0;
        spi_miso_oe = 1'b0;
        unique case (state)
            ST_ADDR:       addr_load = sck_rise && bit_cnt == ADDR_LAST && !cs_s;
            ST_FETCH_REQ:  begin mem_rd = !cs_s; tx_clear = 1'b0; end
            ST_FETCH_WAIT: begin tx_clear = 1'b0; load_first = rd_q; end
            ST_STREAM: begin
                tx_clear    = cs_s;
                fill_buf    = rd_q;
                rise_en     = sck_rise;
                fall_en     = sck_fall;
                mem_rd      = pf_req && !cs_s;
                spi_miso_oe = !cs_s;
            end
            default: ;
        endcase
    end

    spi_rdseq_addr #(.ADDR_W(ADDR_W)) addr_i (
        .clk(clk), .rst_n(rst_n),
        .load(addr_load), .load_val(addr_w),
        .step(mem_rd), .addr(mem_addr)
    );

    spi_rdseq_txsr #(.DATA_W(DATA_W)) txsr_i (
        .clk(clk), .rst_n(rst_n),
        .clear(tx_clear), .load_first(load_first), .fill_buf(fill_buf),
        .rdata(mem_rdata), .rise_en(rise_en), .fall_en(fall_en),
        .bit_out(tx_bit), .pf_req(pf_req)
    );

    assign spi_miso = spi_miso_oe & tx_bit;

    assert_oe_needs_read_op_R2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_miso_oe |-> opcode_q == READ_OP);
    assert_rd_single_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);
    assert_select_high_idles_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !spi_miso_oe);
    assert_start_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !cs_fall) |=> state == ST_IDLE);
endmodule

// File: tb/spi_rdseq_tb_top.sv
module spi_rdseq_tb_top;
    localparam int HALF = 8;
    localparam logic [7:0] RD = 8'h03;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic miso, miso_oe, mem_rd;
    logic [16:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    spi_rdseq dut_i (
        .clk(clk), .rst_n(rst_n),
        .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
        .spi_miso(miso), .spi_miso_oe(miso_oe),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] pat(input logic [16:0] a);
        int ai = int'(a);
        return 8'((ai * 29) ^ (ai >> 9) ^ 90);
    endfunction

    always @(posedge clk) if (mem_rd) mem_rdata <= pat(mem_addr);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic spi_bit(input logic b, output logic s, output logic oe);
        mosi = b;
        repeat (HALF) @(negedge clk);
        s  = miso;
        oe = miso_oe;
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
        sck = 1'b0;
    endtask

    // one transaction: command, 24-bit address, nbytes full bytes, tail extra bits
    task automatic xfer(input logic [7:0] op, input logic [23:0] a24,
                        input int nbytes, input int tail, input string req);
        logic s, oe;
        logic [7:0] got;
        bit oe_early = 0;
        bit oe_seen  = 0;
        bit oe_all   = 1;
        logic [16:0] a = a24[16:0];
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 7; i >= 0; i--) begin spi_bit(op[i], s, oe); oe_early |= oe; end
        for (int i = 23; i >= 0; i--) begin spi_bit(a24[i], s, oe); oe_early |= oe; end
        check(!oe_early, "R9 oe during cmd/addr", int'(oe_early), 0);
        for (int k = 0; k < nbytes; k++) begin
            got = '0;
            for (int j = 7; j >= 0; j--) begin
                spi_bit(logic'((j + k) % 2), s, oe);   // R4: toggling junk on data input
                got[j] = s;
                oe_seen |= oe;
                oe_all  &= oe;
            end
            if (op == RD)
                check(got == pat(a) && oe_all, req, int'(got), int'(pat(a)));
            a = a + 17'd1;
        end
        for (int j = 0; j < tail; j++) begin spi_bit(1'b1, s, oe); oe_seen |= oe; end
        if (op != RD)
            check(!oe_seen, "R2 oe after other opcode", int'(oe_seen), 0);
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
        check(!miso_oe, "R8 oe off after select rise", int'(miso_oe), 0);
        repeat (2 * HALF) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check(!miso_oe && !mem_rd, "R9 reset state", int'({miso_oe, mem_rd}), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(!miso_oe && !mem_rd, "R9 idle after reset", int'({miso_oe, mem_rd}), 0);

        // R1 R5 R6: sweep of start addresses and burst lengths
        for (int i = 0; i < 14; i++)
            xfer(RD, 24'((i * 24'h2345 + i) & 24'h1FFFF), 1 + (i % 3), 0, "R1/R5/R6 stream byte");
        // R3: junk in upper 7 address bits, R7: wrap from top to zero
        xfer(RD, 24'hFE0000 | 24'h1FFFE, 4, 0, "R3/R7 wrap with upper bits set");
        xfer(RD, 24'h01FFFF, 2, 0, "R7 wrap from last");
        // R2: other opcodes
        xfer(8'h0B, 24'h000010, 2, 0, "R2");
        xfer(8'h00, 24'h000000, 1, 0, "R2");
        xfer(8'hFF, 24'hFFFFFF, 1, 3, "R2");
        xfer(8'h83, 24'h000020, 1, 0, "R2");
        // R8: abort inside a byte, then a clean transaction
        xfer(RD, 24'h00ABCD, 1, 3, "R8 byte before abort");
        xfer(RD, 24'h010000, 3, 0, "R8 fresh transaction after abort");
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 180000) begin @(posedge clk); cyc++; end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule